// File: doc/BRIEF.md
# Flash Operation Status Reporter

This block produces the status word that a parallel NOR flash returns while an internal program, erase or buffered-write job is running. A small mode machine follows the job through its life (start, suspend, resume, completion, buffer abort, timeout fault). The word returned on each read depends on that mode, on the byte being programmed, and on whether the read targets the sector that owns the job. Some status bits carry the complement of the programmed data. Some flip on every completed read. Reads that have nothing to report return the array byte supplied on an input port.

The target sector and the data byte come from a write-strobe capture stage. It takes the sector bits when the second of the two active-low write strobes goes low. It takes the data byte when the first of them returns high. A job is started on a command, and it takes the sector and the data captured most recently.

Top module: `flash_status_reporter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle mode. `ready` reads 1 and `rd_data` reads 0x00 from the next cycle. In idle mode, every read returns `arr_data`.
- R2: The sector bits `wr_sec` are taken at the first clock edge at which `we_n` and `ce_n` are both low. The byte `wr_data` is taken at the first clock edge at which either strobe is high again. Later changes of either input have no effect on the captured values.
- R3: During a program job (command code 1 from idle), a read returns the following: bit 7 is the complement of bit 7 of the captured byte, bit 6 is the read toggle, and bit 2 is the erase toggle. Bit 2 stays unchanged from read to read. Bits 4, 3, 1 and 0 read 0, and `ready` is 0. Every read in a busy mode inverts the read toggle, so two consecutive busy reads differ in bit 6.
- R4: During an erase job (command code 2 from idle), a read returns the following: bit 7 reads 0, bit 3 reads 1, and bits 6 and 2 both invert on each read. `ready` is 0.
- R5: A pulse on `err_inject` during a busy mode makes bit 5 read 1. Bit 5 reads 0 once a new job starts or the job completes (command code 6).
- R6: Command code 3 from idle starts a buffered write. Its status is the same as the program status, with bit 1 reading 0. Command code 7 moves it to the aborted state: there bit 1 reads 1, `ready` stays 0, and command code 6 returns the block to idle.
- R7: Command code 4 during an erase job suspends it, and `ready` goes to 1. A read of the job's sector then returns bit 7 = 1, a held bit 6 and an inverting bit 2, with all other bits 0. A read of any other sector returns `arr_data`. Command code 5 resumes the erase.
- R8: Command code 4 during a program job suspends it, and `ready` goes to 1. A read of the job's sector returns 0xFF. A read of any other sector returns `arr_data`. Command code 5 resumes the program job.
- R9: Command code 1 while an erase is suspended starts a nested program job. It uses the program status with `ready` = 0. Command code 6 ends the nested job and returns the block to the suspended erase.
- R10: Command code 6 during a program or erase job returns the block to idle, with `ready` = 1 and reads returning `arr_data`.
- R11: Asserting `rst_n` in the middle of a job abandons the job. Commands presented while `rst_n` is low have no effect.
- R12: A command code that has no transition in the current mode is ignored. Examples are code 4 or code 5 in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| we_n | input | 1 | Write-enable strobe, active low |
| ce_n | input | 1 | Chip-enable strobe, active low |
| wr_sec | input | SEC_W | Sector-select address bits of a write |
| wr_data | input | 8 | Data byte of a write |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (1 program, 2 erase, 3 buffer, 4 suspend, 5 resume, 6 done, 7 abort) |
| err_inject | input | 1 | Marks the running job as timed out |
| rd_stb | input | 1 | One-cycle pulse marking a completed read |
| rd_sec | input | SEC_W | Sector-select address bits of the read |
| arr_data | input | 8 | Array byte returned when no status applies |
| rd_data | output | 8 | Word returned by the last read |
| ready | output | 1 | 1 when no job is busy |

## Verification
The hardest state to reach is the nested program inside a suspended erase. The erase toggle must keep its value across the nested job, so that bit 2 continues from that value when the block returns to the suspended sector. The stimulus table runs through erase, suspend, in-sector and out-of-sector reads, nested program, done and resume in one continuous pass. The expected words of the table follow the two toggles step by step. A separate strobe sequence changes address and data between the two falling edges and the two rising edges. A wrong choice of capture edge then shows up as a wrong bit 7 and a wrong sector.

// File: rtl/flash_stat_pkg.sv
// Shared types and helpers of the flash status reporter.
// Assumes the 3-bit command code set listed below.
package flash_stat_pkg;

    typedef enum logic [2:0] {
        M_IDLE,
        M_PROG,
        M_ERASE,
        M_ESUS,
        M_ESPRG,
        M_PSUS,
        M_BUF,
        M_BUF_ABT
    } fmode_t;

    localparam logic [2:0] OP_NOP   = 3'd0;
    localparam logic [2:0] OP_PROG  = 3'd1;
    localparam logic [2:0] OP_ERASE = 3'd2;
    localparam logic [2:0] OP_BUF   = 3'd3;
    localparam logic [2:0] OP_SUSP  = 3'd4;
    localparam logic [2:0] OP_RES   = 3'd5;
    localparam logic [2:0] OP_DONE  = 3'd6;
    localparam logic [2:0] OP_ABORT = 3'd7;

    localparam int STAT_W = 8;

    // Modes in which a job keeps the device busy.
    function automatic logic is_active(fmode_t m);
        return m inside {M_PROG, M_ERASE, M_ESPRG, M_BUF, M_BUF_ABT};
    endfunction

    // Modes that report ready.
    function automatic logic is_ready(fmode_t m);
        return m inside {M_IDLE, M_ESUS, M_PSUS};
    endfunction

endpackage

// File: rtl/flash_wr_capture.sv
// Write-strobe capture: takes the sector bits when both active-low
// strobes are first seen low together, and takes the data byte when
// the first strobe is first seen high again. Assumes the strobes
// are already synchronous to clk.
module flash_wr_capture #(
    parameter int SEC_W = 2,
    parameter int DAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_n,
    input  logic             ce_n,
    input  logic [SEC_W-1:0] wr_sec,
    input  logic [DAT_W-1:0] wr_data,
    output logic [SEC_W-1:0] tgt_sec,
    output logic [DAT_W-1:0] tgt_data
);

    logic both_low;
    logic both_low_q;

    assign both_low = !we_n && !ce_n;

    // Track the strobe pair and latch address/data on its edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            both_low_q <= 1'b0;
            tgt_sec    <= '0;
            tgt_data   <= '0;
        end else begin
            both_low_q <= both_low;
            if (both_low && !both_low_q)
                tgt_sec <= wr_sec;
            if (!both_low && both_low_q)
                tgt_data <= wr_data;
        end
    end

endmodule

// File: rtl/flash_op_fsm.sv
// Job mode machine: follows program, erase and buffered-write jobs
// through start, suspend, resume, completion and abort. It holds the
// job's sector, its data byte and a timeout flag. Commands without a
// transition in the current mode are ignored.
module flash_op_fsm
    import flash_stat_pkg::*;
#(
    parameter int SEC_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic              err_inject,
    input  logic [SEC_W-1:0]  tgt_sec,
    input  logic [STAT_W-1:0] tgt_data,
    output fmode_t            mode,
    output logic [SEC_W-1:0]  op_sec,
    output logic [STAT_W-1:0] pdata,
    output logic              tmo
);

    // Advance the mode and latch the job context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= M_IDLE;
            op_sec <= '0;
            pdata  <= '0;
            tmo    <= 1'b0;
        end else begin
            if (err_inject && is_active(mode))
                tmo <= 1'b1;
            if (cmd_valid) begin
                unique case (mode)
                    M_IDLE: begin
                        if (cmd_op inside {OP_PROG, OP_ERASE, OP_BUF}) begin
                            op_sec <= tgt_sec;
                            pdata  <= tgt_data;
                            tmo    <= 1'b0;
                            mode   <= (cmd_op == OP_PROG)  ? M_PROG :
                                      (cmd_op == OP_ERASE) ? M_ERASE : M_BUF;
                        end
                    end
                    M_PROG: begin
                        if (cmd_op == OP_SUSP) mode <= M_PSUS;
                        else if (cmd_op == OP_DONE) begin
                            mode <= M_IDLE;
                            tmo  <= 1'b0;
                        end
                    end
                    M_ERASE: begin
                        if (cmd_op == OP_SUSP) mode <= M_ESUS;
                        else if (cmd_op == OP_DONE) begin
                            mode <= M_IDLE;
                            tmo  <= 1'b0;
                        end
                    end
                    M_ESUS: begin
                        if (cmd_op == OP_RES) mode <= M_ERASE;
                        else if (cmd_op == OP_PROG) begin
                            pdata <= tgt_data;
                            tmo   <= 1'b0;
                            mode  <= M_ESPRG;
                        end
                    end
                    M_ESPRG: begin
                        if (cmd_op == OP_DONE) begin
                            mode <= M_ESUS;
                            tmo  <= 1'b0;
                        end
                    end
                    M_PSUS: begin
                        if (cmd_op == OP_RES) mode <= M_PROG;
                    end
                    M_BUF: begin
                        if (cmd_op == OP_ABORT) mode <= M_BUF_ABT;
                        else if (cmd_op == OP_DONE) begin
                            mode <= M_IDLE;
                            tmo  <= 1'b0;
                        end
                    end
                    M_BUF_ABT: begin
                        if (cmd_op == OP_DONE) begin
                            mode <= M_IDLE;
                            tmo  <= 1'b0;
                        end
                    end
                    default: mode <= M_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/flash_stat_encode.sv
// Status word encoder: forms the read word from the mode, the sector
// hit and the job context, and registers it on each read pulse. It
// holds the two read toggles, which invert only when a read completes.
module flash_stat_encode
    import flash_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  fmode_t            mode,
    input  logic              rd_stb,
    input  logic              hit,
    input  logic [STAT_W-1:0] pdata,
    input  logic              tmo,
    input  logic [STAT_W-1:0] arr_data,
    output logic [STAT_W-1:0] rd_data
);

    logic              tg6;
    logic              tg2;
    logic [STAT_W-1:0] word;

    // Select array data or compose the per-mode status word.
    always_comb begin
        word = '0;
        unique case (mode)
            M_PROG, M_ESPRG, M_BUF, M_BUF_ABT: begin
                word[7] = ~pdata[7];
                word[6] = tg6;
                word[5] = tmo;
                word[2] = tg2;
                word[1] = (mode == M_BUF_ABT);
            end
            M_ERASE: begin
                word[6] = tg6;
                word[5] = tmo;
                word[3] = 1'b1;
                word[2] = tg2;
            end
            M_ESUS: begin
                if (hit) begin
                    word[7] = 1'b1;
                    word[6] = tg6;
                    word[2] = tg2;
                end else begin
                    word = arr_data;
                end
            end
            M_PSUS:  word = hit ? '1 : arr_data;
            default: word = arr_data;
        endcase
    end

    // Register the word and advance the toggles on a completed read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            tg6     <= 1'b0;
            tg2     <= 1'b0;
        end else if (rd_stb) begin
            rd_data <= word;
            if (is_active(mode))
                tg6 <= ~tg6;
            if (mode == M_ERASE || (mode == M_ESUS && hit))
                tg2 <= ~tg2;
        end
    end

endmodule

// File: rtl/flash_status_reporter.sv
// Top of the flash status reporter. Joins the write capture, the job
// mode machine and the status encoder. A read hits the job when its
// sector bits equal those of the job.
module flash_status_reporter
    import flash_stat_pkg::*;
#(
    parameter int SEC_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_n,
    input  logic              ce_n,
    input  logic [SEC_W-1:0]  wr_sec,
    input  logic [STAT_W-1:0] wr_data,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic              err_inject,
    input  logic              rd_stb,
    input  logic [SEC_W-1:0]  rd_sec,
    input  logic [STAT_W-1:0] arr_data,
    output logic [STAT_W-1:0] rd_data,
    output logic              ready
);

    logic [SEC_W-1:0]  tgt_sec;
    logic [STAT_W-1:0] tgt_data;
    fmode_t            mode_q;
    logic [SEC_W-1:0]  op_sec;
    logic [STAT_W-1:0] pdata;
    logic              tmo;
    logic              hit;

    assign hit   = (rd_sec == op_sec);
    assign ready = is_ready(mode_q);

    flash_wr_capture #(.SEC_W(SEC_W), .DAT_W(STAT_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_n     (we_n),
        .ce_n     (ce_n),
        .wr_sec   (wr_sec),
        .wr_data  (wr_data),
        .tgt_sec  (tgt_sec),
        .tgt_data (tgt_data)
    );

    flash_op_fsm #(.SEC_W(SEC_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .err_inject (err_inject),
        .tgt_sec    (tgt_sec),
        .tgt_data   (tgt_data),
        .mode       (mode_q),
        .op_sec     (op_sec),
        .pdata      (pdata),
        .tmo        (tmo)
    );

    flash_stat_encode u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_q),
        .rd_stb   (rd_stb),
        .hit      (hit),
        .pdata    (pdata),
        .tmo      (tmo),
        .arr_data (arr_data),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/flash_status_reporter_chk.sv
// Property checker for the flash status reporter, bound to the top.
// It remembers the mode at the previous read so that it can compare
// bit 6 between consecutive busy reads.
module flash_status_reporter_chk
    import flash_stat_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rd_stb,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input fmode_t            mode,
    input logic              tmo,
    input logic              hit,
    input logic [STAT_W-1:0] arr_data,
    input logic [STAT_W-1:0] rd_data,
    input logic              ready
);

    fmode_t prev_mode;

    // Mode seen at the most recent read.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_mode <= M_IDLE;
        else if (rd_stb) prev_mode <= mode;
    end

    p_b6_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && is_active(mode) && is_active(prev_mode) |=> rd_data[6] != $past(rd_data[6]));

    p_erase_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && mode == M_ERASE && !cmd_valid |=> !ready && rd_data[3] && !rd_data[7]);

    p_tmo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && tmo && is_active(mode) |=> rd_data[5]);

    p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && mode == M_BUF_ABT |=> rd_data[1] && !ready);

    p_esus_other_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && mode == M_ESUS && !hit |=> rd_data == $past(arr_data));

    p_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_op == OP_DONE && mode == M_PROG |=> ready);

    p_rst_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ready && rd_data == '0);

endmodule

bind flash_status_reporter flash_status_reporter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_stb    (rd_stb),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .mode      (mode_q),
    .tmo       (tmo),
    .hit       (hit),
    .arr_data  (arr_data),
    .rd_data   (rd_data),
    .ready     (ready)
);

// File: tb/flash_status_reporter_bench.sv
`timescale 1ns/1ps
// Bench: a table-driven pass through every mode, followed by directed
// tests of reset, strobe capture, timeout and reset during a job.
module flash_status_reporter_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we_n = 1'b1;
    logic       ce_n = 1'b1;
    logic [1:0] wr_sec = '0;
    logic [7:0] wr_data = '0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic       err_inject = 1'b0;
    logic       rd_stb = 1'b0;
    logic [1:0] rd_sec = '0;
    logic [7:0] arr_data = 8'h3C;
    logic [7:0] rd_data;
    logic       ready;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    flash_status_reporter #(.SEC_W(2)) u_flash_status_reporter (
        .clk(clk), .rst_n(rst_n), .we_n(we_n), .ce_n(ce_n),
        .wr_sec(wr_sec), .wr_data(wr_data), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .err_inject(err_inject), .rd_stb(rd_stb),
        .rd_sec(rd_sec), .arr_data(arr_data), .rd_data(rd_data),
        .ready(ready)
    );

    // Step fields: command, read sector, expected word, expected ready, requirement.
    localparam logic [17:0] VEC [24] = '{
        {3'd1, 2'd1, 8'h80, 1'b0, 4'd3},   // R3 program start
        {3'd0, 2'd1, 8'hC0, 1'b0, 4'd3},   // R3 bit 6 inverts
        {3'd0, 2'd2, 8'h80, 1'b0, 4'd3},   // R3 any sector
        {3'd4, 2'd2, 8'h3C, 1'b1, 4'd8},   // R8 other sector
        {3'd0, 2'd1, 8'hFF, 1'b1, 4'd8},   // R8 suspended sector
        {3'd5, 2'd1, 8'hC0, 1'b0, 4'd3},   // R3 resumed
        {3'd6, 2'd1, 8'h3C, 1'b1, 4'd10},  // R10 done
        {3'd2, 2'd1, 8'h08, 1'b0, 4'd4},   // R4 erase start
        {3'd0, 2'd1, 8'h4C, 1'b0, 4'd4},   // R4 toggles
        {3'd4, 2'd1, 8'h80, 1'b1, 4'd7},   // R7 suspended sector
        {3'd0, 2'd1, 8'h84, 1'b1, 4'd7},   // R7 bit 2 inverts, bit 6 held
        {3'd0, 2'd0, 8'h3C, 1'b1, 4'd7},   // R7 other sector
        {3'd1, 2'd0, 8'h80, 1'b0, 4'd9},   // R9 nested program
        {3'd0, 2'd0, 8'hC0, 1'b0, 4'd9},   // R9 toggles
        {3'd6, 2'd1, 8'h80, 1'b1, 4'd9},   // R9 back to suspend
        {3'd5, 2'd1, 8'h0C, 1'b0, 4'd4},   // R4 erase resumed
        {3'd6, 2'd1, 8'h3C, 1'b1, 4'd10},  // R10 done
        {3'd3, 2'd1, 8'hC0, 1'b0, 4'd6},   // R6 buffer busy
        {3'd0, 2'd1, 8'h80, 1'b0, 4'd6},   // R6
        {3'd7, 2'd1, 8'hC2, 1'b0, 4'd6},   // R6 abort
        {3'd0, 2'd1, 8'h82, 1'b0, 4'd6},   // R6
        {3'd6, 2'd1, 8'h3C, 1'b1, 4'd6},   // R6 abort cleared
        {3'd4, 2'd1, 8'h3C, 1'b1, 4'd12},  // R12 suspend in idle
        {3'd5, 2'd1, 8'h3C, 1'b1, 4'd12}   // R12 resume in idle
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cmd_valid = 1'b0; rd_stb = 1'b0; err_inject = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic issue(input logic [2:0] op);
        @(negedge clk);
        cmd_valid = (op != 3'd0);
        cmd_op = op;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op = 3'd0;
    endtask

    task automatic do_read(input logic [1:0] sec);
        @(negedge clk);
        rd_sec = sec;
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic pulse_err();
        @(negedge clk);
        err_inject = 1'b1;
        @(negedge clk);
        err_inject = 1'b0;
    endtask

    task automatic write_both(input logic [1:0] sec, input logic [7:0] dat);
        @(negedge clk);
        we_n = 1'b0; ce_n = 1'b0; wr_sec = sec; wr_data = dat;
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        // R1 reset state and idle reads
        do_reset();
        check("R1 word", rd_data, 8'h00);
        check("R1 ready", {7'd0, ready}, 8'h01);
        do_read(2'd3);
        check("R1 idle read", rd_data, 8'h3C);
        arr_data = 8'hA5;
        do_read(2'd0);
        check("R1 idle read", rd_data, 8'hA5);
        arr_data = 8'h3C;

        // Table pass through every mode
        write_both(2'd1, 8'h5A);
        for (int i = 0; i < 24; i++) begin
            logic [17:0] v;
            string tag;
            v = VEC[i];
            issue(v[17:15]);
            do_read(v[14:13]);
            tag = $sformatf("R%0d step %0d", v[3:0], i);
            check(tag, rd_data, v[12:5]);
            check(tag, {7'd0, ready}, {7'd0, v[4]});
        end

        // R2 capture edges
        do_reset();
        @(negedge clk); we_n = 1'b0; wr_sec = 2'd2;
        @(negedge clk); ce_n = 1'b0;
        @(negedge clk); wr_sec = 2'd0; wr_data = 8'h11;
        @(negedge clk); wr_data = 8'h91; we_n = 1'b1;
        @(negedge clk); wr_data = 8'h01;
        @(negedge clk); ce_n = 1'b1;
        issue(3'd1);
        do_read(2'd2);
        check("R2 data at first rise", rd_data, 8'h00);
        issue(3'd4);
        do_read(2'd2);
        check("R2 sector at second fall", rd_data, 8'hFF);
        do_read(2'd0);
        check("R2 other sector", rd_data, 8'h3C);

        // R5 timeout in program and erase
        do_reset();
        issue(3'd1);
        pulse_err();
        do_read(2'd0);
        check("R5 program timeout", rd_data, 8'hA0);
        do_read(2'd0);
        check("R5 program timeout", rd_data, 8'hE0);
        issue(3'd6);
        do_read(2'd0);
        check("R5 cleared at done", rd_data, 8'h3C);
        issue(3'd2);
        do_read(2'd0);
        check("R5 cleared at start", rd_data, 8'h08);
        pulse_err();
        do_read(2'd0);
        check("R5 erase timeout", rd_data, 8'h6C);

        // R11 reset during a job, commands ignored while held
        do_reset();
        issue(3'd2);
        @(negedge clk);
        rst_n = 1'b0; cmd_valid = 1'b1; cmd_op = 3'd1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; cmd_valid = 1'b0; cmd_op = 3'd0;
        check("R11 ready after reset", {7'd0, ready}, 8'h01);
        do_read(2'd0);
        check("R11 array after reset", rd_data, 8'h3C);
        do_read(2'd0);
        check("R11 still idle", {ready, rd_data[6:0]}, {1'b1, 7'h3C});

        summary();
    end

endmodule